// File: doc/BRIEF.md
# Dual Comparator Event Interrupt Unit

This unit is the digital control logic that sits beside two analog comparators. Each comparator's output reaches it as an already-synchronised digital level. At a chosen moment the unit samples both levels. That moment is either every clock or the overflow strobe of one of three timers. The unit tests each sample against a per-comparator condition. When the condition holds it sets a sticky event flag, and the flags feed one shared interrupt request.

The unit also holds the control that reaches the analog side: a connect bit and a 2-bit positive-input select per comparator. A power-down input forces both comparators off. After a comparator connects, the unit blanks its events for a programmable settling interval, counted in clocks. A CPU idle state has no input here, so the comparators keep running through it.

Software reaches the unit through a small write/read port with four 6-bit registers. The interrupt handler reads the flag register to tell which comparator fired. It then clears that flag by writing a 0 to its bit.

Top module: `cmp_event_unit`

## Requirements
- R1: After synchronous reset, every register is 0. `irq`, `rd_data` and `cmp_on` are 0 and `in_sel_a`/`in_sel_b` are 00.
- R2: The register map is as follows. Address 0 controls comparator A and address 1 controls comparator B. In each control register, bit 0 is connect, bit 1 is interrupt enable, bits 3:2 are the condition mode and bits 5:4 are the input select. Address 2 bits 2:0 hold the sample source. Address 3 holds the flags, with bit 0 for A and bit 1 for B. `rd_data` returns the register at `rd_addr` one clock later, and unused bits read 0.
- R3: `in_sel_a`/`in_sel_b` drive the stored input-select fields. `cmp_on[i]` is high one clock after a cycle in which comparator i is connected and power-down is low.
- R4: A sample-source value of 0 samples every clock. Values 1, 2 and 3 sample only in cycles where `tmr_ovf[0]`, `tmr_ovf[1]` or `tmr_ovf[2]` is high. Values 4 to 7 sample every clock.
- R5: Mode 00 fires on a low sample and mode 01 on a high sample. Mode 10 fires when a sample is 0 and the previous sample was 1. Mode 11 fires when a sample is 1 and the previous sample was 0. Edges compare consecutive samples taken since the comparator became active.
- R6: Take the first cycle in which a comparator is active (connected and not powered down) as cycle 0. Samples in cycles 0 to SETTLE_CYC set no flag, and this blanking restarts on every new activation.
- R7: A disconnected comparator sets no flag, whatever its input.
- R8: A flag set by a firing sample is visible one clock later and stays set. Writing address 3 clears each flag whose data bit is 0 and leaves each flag whose data bit is 1 unchanged.
- R9: If a clearing write and a firing sample hit the same flag in the same cycle, the flag ends up 0.
- R10: `irq` is high one clock after a cycle in which some flag is set and its interrupt enable bit is 1.
- R11: While `pdown_mode` is high, both comparators are inactive: no flag is set and `cmp_on` is 0. Leaving power-down starts a fresh settling interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_a_in | input | 1 | Synchronised output of comparator A |
| cmp_b_in | input | 1 | Synchronised output of comparator B |
| tmr_ovf | input | N_TMR | One-cycle timer overflow strobes |
| pdown_mode | input | 1 | Power-down state, forces comparators off |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 6 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 6 | Registered read data |
| irq | output | 1 | Shared comparator interrupt request |
| cmp_on | output | 2 | Per-comparator enable to the analog side |
| in_sel_a | output | 2 | Positive-input select, comparator A |
| in_sel_b | output | 2 | Positive-input select, comparator B |

## Verification
The bench counts clocks across the settling window after connect and again after power-down exit. A counter that is off by one lets a flag appear one clock early, or holds it one clock late. The bench rewrites a flag to 0 while its level condition keeps firing, so a design that lets the hardware set win would read back 1 right after the clear. It pulses the timer strobes that are not selected under a chosen sample source, and holds an input steady in edge modes. A design that samples every clock, or compares against the previous clock rather than the previous sample, would then flag events that should not exist. Long random runs compare the read port, the interrupt and the analog controls each clock against a reference model.

// File: rtl/cmp_evt_pkg.sv
package cmp_evt_pkg;
  typedef enum logic [1:0] {
    MODE_LOW  = 2'b00,
    MODE_HIGH = 2'b01,
    MODE_FALL = 2'b10,
    MODE_RISE = 2'b11
  } cmp_mode_e;

  // Field order sets the bit layout: insel[5:4], mode[3:2], ie[1], conn[0].
  typedef struct packed {
    logic [1:0] insel;
    cmp_mode_e  mode;
    logic       ie;
    logic       conn;
  } ch_ctrl_t;

  localparam int REG_W  = $bits(ch_ctrl_t);
  localparam int ADDR_W = 2;
  localparam int SRC_W  = 3;
  localparam int NCH    = 2;

  localparam logic [ADDR_W-1:0] ADDR_CTRL_A = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CTRL_B = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_SRC    = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_FLAG   = 2'd3;
endpackage

// File: rtl/cmp_strobe_sel.sv
module cmp_strobe_sel #(
  parameter int N_TMR = 3,
  parameter int SRC_W = 3
) (
  input  logic [SRC_W-1:0] src,
  input  logic [N_TMR-1:0] tmr_ovf,
  output logic             strobe
);
  // Code 0 and codes above N_TMR sample every clock; code k picks timer k-1.
  always_comb begin
    strobe = 1'b1;
    for (int i = 0; i < N_TMR; i++) begin
      if (src == SRC_W'(i + 1)) strobe = tmr_ovf[i];
    end
  end
endmodule

// File: rtl/cmp_channel.sv
module cmp_channel
  import cmp_evt_pkg::*;
#(
  parameter int SETTLE_CYC = 200
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      active,
  input  logic      strobe,
  input  logic      cmp_in,
  input  cmp_mode_e mode,
  input  logic      flag_clr,
  output logic      flag
);
  localparam int CNT_W = (SETTLE_CYC < 1) ? 1 : $clog2(SETTLE_CYC + 1);

  logic             active_d;
  logic [CNT_W-1:0] cnt_q;
  logic             samp_q;
  logic             have_q;
  logic             flag_q;
  logic             ready;
  logic             cond;
  logic             hit;

  assign ready = active && active_d && (cnt_q == '0);

  always_comb begin
    unique case (mode)
      MODE_LOW:  cond = !cmp_in;
      MODE_HIGH: cond = cmp_in;
      MODE_FALL: cond = have_q && samp_q && !cmp_in;
      MODE_RISE: cond = have_q && !samp_q && cmp_in;
      default:   cond = 1'b0;
    endcase
  end

  assign hit = strobe && ready && cond;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_d <= 1'b0;
      cnt_q    <= '0;
      samp_q   <= 1'b0;
      have_q   <= 1'b0;
      flag_q   <= 1'b0;
    end else begin
      active_d <= active;
      if (active && !active_d) cnt_q <= CNT_W'(SETTLE_CYC);
      else if (active && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
      if (!active) begin
        have_q <= 1'b0;
      end else if (strobe) begin
        samp_q <= cmp_in;
        have_q <= 1'b1;
      end
      flag_q <= (flag_q | hit) & ~flag_clr;
    end
  end

  assign flag = flag_q;

  // R6: no flag may rise while the settle count is still running
  assert_settle_blank_R6: assert property (@(posedge clk) disable iff (rst)
    (active && cnt_q != '0) |=> !$rose(flag_q));
  // R7, R11: an inactive comparator never sets its flag
  assert_idle_no_event_R7: assert property (@(posedge clk) disable iff (rst)
    !active |=> !$rose(flag_q));
  // R8: flag only drops after a software clear
  assert_sticky_flag_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(flag_q) |-> $past(flag_clr));
  // R9: a clear always leaves the flag low
  assert_clear_wins_R9: assert property (@(posedge clk) disable iff (rst)
    flag_clr |=> !flag_q);
  // R4: held sample changes only on a strobe while active
  assert_sample_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !(strobe && active) |=> $stable(samp_q));
endmodule

// File: rtl/cmp_event_unit.sv
module cmp_event_unit
  import cmp_evt_pkg::*;
#(
  parameter int SETTLE_CYC = 200,
  parameter int N_TMR      = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmp_a_in,
  input  logic              cmp_b_in,
  input  logic [N_TMR-1:0]  tmr_ovf,
  input  logic              pdown_mode,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [REG_W-1:0]  rd_data,
  output logic              irq,
  output logic [NCH-1:0]    cmp_on,
  output logic [1:0]        in_sel_a,
  output logic [1:0]        in_sel_b
);
  ch_ctrl_t           ctrl_q [NCH];
  logic [SRC_W-1:0]   src_q;
  logic [NCH-1:0]     cmp_vec;
  logic [NCH-1:0]     active;
  logic [NCH-1:0]     ie_vec;
  logic [NCH-1:0]     flag;
  logic [NCH-1:0]     flag_clr;
  logic               strobe;
  logic [REG_W-1:0]   rd_q;
  logic               irq_q;
  logic [NCH-1:0]     on_q;

  assign cmp_vec = {cmp_b_in, cmp_a_in};

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      active[i]   = ctrl_q[i].conn && !pdown_mode;
      ie_vec[i]   = ctrl_q[i].ie;
      flag_clr[i] = wr_en && (wr_addr == ADDR_FLAG) && !wr_data[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NCH; i++) ctrl_q[i] <= '0;
      src_q <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < NCH; i++) begin
        if (wr_addr == ADDR_CTRL_A + ADDR_W'(i)) ctrl_q[i] <= ch_ctrl_t'(wr_data);
      end
      if (wr_addr == ADDR_SRC) src_q <= wr_data[SRC_W-1:0];
    end
  end

  cmp_strobe_sel #(.N_TMR(N_TMR), .SRC_W(SRC_W)) u_sel (
    .src     (src_q),
    .tmr_ovf (tmr_ovf),
    .strobe  (strobe)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    cmp_channel #(.SETTLE_CYC(SETTLE_CYC)) u_ch (
      .clk      (clk),
      .rst      (rst),
      .active   (active[g]),
      .strobe   (strobe),
      .cmp_in   (cmp_vec[g]),
      .mode     (ctrl_q[g].mode),
      .flag_clr (flag_clr[g]),
      .flag     (flag[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q  <= '0;
      irq_q <= 1'b0;
      on_q  <= '0;
    end else begin
      unique case (rd_addr)
        ADDR_CTRL_A: rd_q <= ctrl_q[0];
        ADDR_CTRL_B: rd_q <= ctrl_q[1];
        ADDR_SRC:    rd_q <= REG_W'(src_q);
        default:     rd_q <= REG_W'(flag);
      endcase
      irq_q <= |(flag & ie_vec);
      on_q  <= active;
    end
  end

  assign rd_data  = rd_q;
  assign irq      = irq_q;
  assign cmp_on   = on_q;
  assign in_sel_a = ctrl_q[0].insel;
  assign in_sel_b = ctrl_q[1].insel;

  // R10: a request needs an enabled, set flag one clock earlier
  assert_irq_source_R10: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(|(flag & ie_vec)));
  // R11: power-down turns both analog enables off
  assert_pdown_off_R11: assert property (@(posedge clk) disable iff (rst)
    pdown_mode |=> (cmp_on == '0));
  // R3: enable output never on for a disconnected channel
  assert_on_needs_conn_R3: assert property (@(posedge clk) disable iff (rst)
    !ctrl_q[0].conn |=> !cmp_on[0]);
endmodule

// File: tb/cmp_event_unit_tb.sv
module cmp_event_unit_tb;
  localparam int CLK_P  = 10;
  localparam int SETTLE = 5;

  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] cin;
  logic [2:0] tmr;
  logic       pd;
  logic       we;
  logic [1:0] wa;
  logic [5:0] wd;
  logic [1:0] ra;
  logic [5:0] rd_data;
  logic       irq;
  logic [1:0] cmp_on;
  logic [1:0] in_sel_a, in_sel_b;

  int n_chk = 0;
  int n_err = 0;
  bit auto_on = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  cmp_event_unit #(.SETTLE_CYC(SETTLE), .N_TMR(3)) u_dut (
    .clk(clk), .rst(rst), .cmp_a_in(cin[0]), .cmp_b_in(cin[1]),
    .tmr_ovf(tmr), .pdown_mode(pd), .wr_en(we), .wr_addr(wa),
    .wr_data(wd), .rd_addr(ra), .rd_data(rd_data), .irq(irq),
    .cmp_on(cmp_on), .in_sel_a(in_sel_a), .in_sel_b(in_sel_b)
  );

  // Reference model state
  logic [5:0] m_ctrl [2];
  logic [2:0] m_src;
  logic [1:0] m_flag, m_actd, m_samp, m_have;
  int         m_cnt [2];
  logic [5:0] exp_rd;
  logic       exp_irq;
  logic [1:0] exp_on, exp_sel_a, exp_sel_b;

  always @(posedge clk) begin : model
    logic [1:0] act;
    logic stb, rdy, c, hit, clr;
    if (rst) begin
      m_ctrl[0] = 0; m_ctrl[1] = 0; m_src = 0; m_flag = 0; m_actd = 0;
      m_samp = 0; m_have = 0; m_cnt[0] = 0; m_cnt[1] = 0;
      exp_rd = 0; exp_irq = 0; exp_on = 0; exp_sel_a = 0; exp_sel_b = 0;
    end else begin
      case (ra)
        2'd0: exp_rd = m_ctrl[0];
        2'd1: exp_rd = m_ctrl[1];
        2'd2: exp_rd = {3'b000, m_src};
        default: exp_rd = {4'b0000, m_flag};
      endcase
      exp_irq = (m_flag[0] & m_ctrl[0][1]) | (m_flag[1] & m_ctrl[1][1]);
      for (int i = 0; i < 2; i++) act[i] = m_ctrl[i][0] & ~pd;
      exp_on = act;
      stb = (m_src == 3'd1) ? tmr[0] : (m_src == 3'd2) ? tmr[1] :
            (m_src == 3'd3) ? tmr[2] : 1'b1;
      for (int i = 0; i < 2; i++) begin
        rdy = act[i] && m_actd[i] && (m_cnt[i] == 0);
        case (m_ctrl[i][3:2])
          2'b00: c = !cin[i];
          2'b01: c = cin[i];
          2'b10: c = m_have[i] && m_samp[i] && !cin[i];
          default: c = m_have[i] && !m_samp[i] && cin[i];
        endcase
        hit = stb && rdy && c;
        clr = we && (wa == 2'd3) && !wd[i];
        m_flag[i] = (m_flag[i] | hit) & ~clr;
        if (act[i] && !m_actd[i]) m_cnt[i] = SETTLE;
        else if (act[i] && m_cnt[i] > 0) m_cnt[i] = m_cnt[i] - 1;
        m_actd[i] = act[i];
        if (!act[i]) m_have[i] = 1'b0;
        else if (stb) begin m_samp[i] = cin[i]; m_have[i] = 1'b1; end
      end
      if (we) begin
        case (wa)
          2'd0: m_ctrl[0] = wd;
          2'd1: m_ctrl[1] = wd;
          2'd2: m_src = wd[2:0];
          default: ;
        endcase
      end
      exp_sel_a = m_ctrl[0][5:4];
      exp_sel_b = m_ctrl[1][5:4];
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (auto_on && !rst) begin
      chk("R2 read data", 8'(rd_data), 8'(exp_rd));
      chk("R10 irq", 8'(irq), 8'(exp_irq));
      chk("R3 cmp_on/R11", 8'(cmp_on), 8'(exp_on));
      chk("R3 in_sel_a", 8'(in_sel_a), 8'(exp_sel_a));
      chk("R3 in_sel_b", 8'(in_sel_b), 8'(exp_sel_b));
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [5:0] d);
    we = 1'b1; wa = a; wd = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1; cin = 0; tmr = 0; pd = 0; we = 0; wa = 0; wd = 0; ra = 2'd3;
    repeat (4) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 rd_data", 8'(rd_data), 8'h00);
    chk("R1 irq", 8'(irq), 8'h00);
    chk("R1 cmp_on", 8'(cmp_on), 8'h00);
    chk("R1 in_sel_a", 8'(in_sel_a), 8'h00);
    auto_on = 1;

    // R6 settling blank after connect: A level-high, insel 10, ie on
    cin = 2'b01;
    wr(2'd0, 6'h27);
    tick(SETTLE + 2);
    chk("R6 blanked", 8'(rd_data[0]), 8'h00);
    tick(1);
    chk("R6 first event", 8'(rd_data[0]), 8'h01);
    chk("R10 irq raised", 8'(irq), 8'h01);
    chk("R3 in_sel_a", 8'(in_sel_a), 8'h02);
    chk("R3 cmp_on", 8'(cmp_on), 8'h01);

    // R8 sticky then cleared by writing 0
    cin = 2'b00;
    tick(3);
    chk("R8 sticky", 8'(rd_data[0]), 8'h01);
    wr(2'd3, 6'h3E);
    tick(1);
    chk("R8 cleared", 8'(rd_data[0]), 8'h00);
    chk("R10 irq dropped", 8'(irq), 8'h00);

    // R9 clear beats simultaneous set
    cin = 2'b01;
    tick(2);
    wr(2'd3, 6'h3E);
    tick(1);
    chk("R9 clear wins", 8'(rd_data[0]), 8'h00);
    tick(1);
    chk("R9 set resumes", 8'(rd_data[0]), 8'h01);

    // R5 rising edge mode
    cin = 2'b00;
    wr(2'd0, 6'h2F);
    wr(2'd3, 6'h3E);
    tick(3);
    chk("R5 rise none", 8'(rd_data[0]), 8'h00);
    cin = 2'b01;
    tick(2);
    chk("R5 rise seen", 8'(rd_data[0]), 8'h01);
    wr(2'd3, 6'h3E);
    tick(3);
    chk("R5 steady high no edge", 8'(rd_data[0]), 8'h00);
    // R5 falling edge mode
    wr(2'd0, 6'h2B);
    wr(2'd3, 6'h3E);
    tick(2);
    chk("R5 fall none", 8'(rd_data[0]), 8'h00);
    cin = 2'b00;
    tick(2);
    chk("R5 fall seen", 8'(rd_data[0]), 8'h01);

    // R4 timer-1 strobe only
    wr(2'd3, 6'h3E);
    wr(2'd0, 6'h2F);
    wr(2'd2, 6'h02);
    cin = 2'b01; tmr = 3'b101;
    tick(1);
    tmr = 3'b000;
    tick(2);
    chk("R4 unselected strobes", 8'(rd_data[0]), 8'h00);
    tmr = 3'b010;
    tick(1);
    tmr = 3'b000;
    tick(1);
    chk("R4 selected strobe", 8'(rd_data[0]), 8'h01);

    // R11 power-down
    pd = 1'b1;
    wr(2'd2, 6'h00);
    wr(2'd0, 6'h27);
    wr(2'd3, 6'h3E);
    tick(3);
    chk("R11 no event in pdown", 8'(rd_data[0]), 8'h00);
    chk("R11 cmp_on off", 8'(cmp_on), 8'h00);
    pd = 1'b0;
    tick(SETTLE + 2);
    chk("R11 resettle blank", 8'(rd_data[0]), 8'h00);
    tick(1);
    chk("R11 event after resettle", 8'(rd_data[0]), 8'h01);

    // R7 disconnected
    wr(2'd0, 6'h26);
    wr(2'd3, 6'h3E);
    tick(4);
    chk("R7 no event disconnected", 8'(rd_data[0]), 8'h00);
    chk("R7 cmp_on off", 8'(cmp_on), 8'h00);

    // Random phase against the model
    for (int k = 0; k < 5000; k++) begin
      cin = 2'($urandom);
      tmr = (($urandom % 4) == 0) ? 3'($urandom) : 3'b000;
      if (($urandom % 60) == 0) pd = ~pd;
      we = (($urandom % 5) == 0);
      wa = 2'($urandom);
      wd = 6'($urandom);
      ra = 2'($urandom);
      @(negedge clk);
    end
    we = 1'b0;
    tick(2);
    summary();
  end
endmodule